// File: doc/BRIEF.md
# Predicate Mask Fetch Unit

This unit supplies the predicate mask for one operand register of a vector-capable pipeline. It keeps two redirection tables of per-operand predication entries: one is consulted for integer operands and the other for floating-point operands, so the two register classes are predicated independently. Each entry carries an enable flag, a zeroing flag, an invert flag and the number of an integer register that holds the mask bits.

A lookup names an operand slot and a register class. The unit reads the selected entry in the same cycle and drives the entry's register number on an integer register-file read port. The port returns the data combinationally. One cycle later the unit presents the mask and the zeroing mode, together with a one-cycle valid strobe. An entry that is not enabled yields an all-ones mask, so every element runs. An enabled entry yields the register value, or its complement when the invert flag is set. Predication does not depend on whether the operand is a vector or a scalar: an operand is predicated whenever its entry is enabled. The mask is XLEN bits wide, and this sets the vector length limit. The two-state response machine has the states `ST_IDLE`, where no result is presented, and `ST_RESP`, where the registered result is presented with the strobe. The transition `go_resp` is taken on any cycle with a request, from either state. The transition `go_idle` is taken from `ST_RESP` on any cycle without a request.

Top module: `pred_mask_unit`

## Requirements
- R1: After reset, mask_valid is 0, mask is all ones, zeroing is 0, and every table entry in both classes is disabled.
- R2: Each cycle with req_valid high produces mask_valid high in exactly the following cycle. Back-to-back requests give back-to-back strobes, and mask_valid is 0 one cycle after a cycle without a request.
- R3: A lookup of a disabled entry returns a mask of all ones with zeroing 0.
- R4: A lookup of an enabled entry with invert 0 drives the entry's register number on rf_raddr in the request cycle. One cycle later it returns the rf_rdata seen in that cycle.
- R5: A lookup of an enabled entry with invert 1 returns the bitwise complement of that register value.
- R6: A lookup of an enabled entry returns the entry's zeroing flag on zeroing.
- R7: An enabled entry with register number 0 returns all zeros, or all ones when inverted, whatever rf_rdata carries.
- R8: req_fp=0 selects the integer table and req_fp=1 selects the floating-point table, and wr_fp selects the written table in the same way. A write to one class leaves the same slot of the other class unchanged.
- R9: A table write takes effect from the next cycle. A lookup in the same cycle as a write to that slot sees the old entry.
- R10: In cycles without a request, mask and zeroing hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write enable |
| wr_fp | input | 1 | Written table: 0 integer, 1 floating-point |
| wr_slot | input | 5 | Written operand slot |
| wr_active | input | 1 | Enable flag to write |
| wr_zero | input | 1 | Zeroing flag to write |
| wr_inv | input | 1 | Invert flag to write |
| wr_ridx | input | 5 | Mask register number to write |
| req_valid | input | 1 | Lookup request |
| req_fp | input | 1 | Looked-up table: 0 integer, 1 floating-point |
| req_slot | input | 5 | Looked-up operand slot |
| rf_raddr | output | 5 | Integer register-file read address (combinational) |
| rf_rdata | input | XLEN | Integer register-file read data (combinational) |
| mask_valid | output | 1 | Result strobe, one cycle after a request |
| mask | output | XLEN | Predicate mask |
| zeroing | output | 1 | Zeroing mode of the looked-up entry |

## Verification
The bench sweeps every slot of both classes through all eight flag combinations, and a table model predicts each result. A unit that mixes up the classes would return the other table's mask. A unit that forgot the invert flag, or applied it to disabled entries, would return complemented data or lose the all-ones default. The bench returns a nonzero word for register 0, so a unit that passed that word through would be caught on the register-0 cases. Further cases cover a write and a lookup of the same slot in one cycle, which would expose a write-through path, as well as back-to-back requests and idle cycles, which would expose a missing strobe or an output that drifts while idle.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } pmf_state_e;

    typedef enum logic {
        CLS_INT = 1'b0,
        CLS_FP  = 1'b1
    } pmf_cls_e;

    localparam int unsigned PMF_CLASSES = 2;
endpackage

// File: rtl/pmf_table.sv
module pmf_table #(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned RIDX_W = 5,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned ENT_W  = RIDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_cls,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ENT_W-1:0]  wr_ent,
    input  logic              rd_cls,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [ENT_W-1:0]  rd_ent
);
    import pmf_pkg::*;

    logic [ENT_W-1:0] cls_rd [PMF_CLASSES];

    for (genvar g = 0; g < PMF_CLASSES; g++) begin : g_cls
        logic [ENT_W-1:0] mem [SLOTS];
        logic             sel;

        assign sel = wr_en && (wr_cls == 1'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
            end else if (sel) begin
                mem[wr_slot] <= wr_ent;
            end
        end

        assign cls_rd[g] = mem[rd_slot];
    end

    always_comb begin
        rd_ent = cls_rd[rd_cls];
    end
endmodule

// File: rtl/pmf_resp_fsm.sv
module pmf_resp_fsm #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned RIDX_W = 5,
    localparam int unsigned ENT_W = RIDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ENT_W-1:0] ent,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             mask_valid,
    output logic [XLEN-1:0]  mask,
    output logic             zeroing
);
    import pmf_pkg::*;

    typedef struct packed {
        logic              active;
        logic              zero;
        logic              inv;
        logic [RIDX_W-1:0] ridx;
    } ent_t;

    ent_t       e;
    pmf_state_e state, state_nx;
    logic [XLEN-1:0] raw, mask_nx;
    logic            zero_nx;

    assign e = ent_t'(ent);

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        raw     = (e.ridx == '0) ? '0 : rf_rdata;
        mask_nx = e.active ? (e.inv ? ~raw : raw) : '1;
        zero_nx = e.active & e.zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '1;
            zeroing <= 1'b0;
        end else if (req_valid) begin
            mask    <= mask_nx;
            zeroing <= zero_nx;
        end
    end

    assign mask_valid = (state == ST_RESP);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mask_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mask_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(mask) && $stable(zeroing))); // R10
endmodule

// File: rtl/pred_mask_unit.sv
module pred_mask_unit #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned RIDX_W = 5,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned ENT_W  = RIDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_fp,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_active,
    input  logic              wr_zero,
    input  logic              wr_inv,
    input  logic [RIDX_W-1:0] wr_ridx,
    input  logic              req_valid,
    input  logic              req_fp,
    input  logic [SLOT_W-1:0] req_slot,
    output logic [RIDX_W-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              mask_valid,
    output logic [XLEN-1:0]   mask,
    output logic              zeroing
);
    typedef struct packed {
        logic              active;
        logic              zero;
        logic              inv;
        logic [RIDX_W-1:0] ridx;
    } ent_t;

    ent_t wr_ent, rd_ent;
    logic [ENT_W-1:0] rd_bits;

    assign wr_ent = '{active: wr_active, zero: wr_zero, inv: wr_inv, ridx: wr_ridx};

    pmf_table #(.SLOTS(SLOTS), .RIDX_W(RIDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_cls  (wr_fp),
        .wr_slot (wr_slot),
        .wr_ent  (ENT_W'(wr_ent)),
        .rd_cls  (req_fp),
        .rd_slot (req_slot),
        .rd_ent  (rd_bits)
    );

    assign rd_ent   = ent_t'(rd_bits);
    assign rf_raddr = rd_ent.ridx;

    pmf_resp_fsm #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .ent        (rd_bits),
        .rf_rdata   (rf_rdata),
        .mask_valid (mask_valid),
        .mask       (mask),
        .zeroing    (zeroing)
    );

    AST_DISABLED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rd_ent.active) |=> ((&mask) && !zeroing)); // R3
    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_ent.active && !rd_ent.inv && rd_ent.ridx != '0)
            |=> (mask == $past(rf_rdata))); // R4
    AST_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_ent.active && rd_ent.inv && rd_ent.ridx != '0)
            |=> (mask == ~$past(rf_rdata))); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_ent.active) |=> (zeroing == $past(rd_ent.zero))); // R6
    AST_REG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_ent.active && rd_ent.ridx == '0)
            |=> (mask == {XLEN{$past(rd_ent.inv)}})); // R7
endmodule

// File: tb/pred_mask_unit_tb.sv
module pred_mask_unit_tb;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_fp = 0, wr_active = 0, wr_zero = 0, wr_inv = 0;
    logic [4:0] wr_slot = 0, wr_ridx = 0;
    logic req_valid = 0, req_fp = 0;
    logic [4:0] req_slot = 0;
    logic [4:0] rf_raddr;
    logic [XLEN-1:0] rf_rdata;
    logic mask_valid, zeroing;
    logic [XLEN-1:0] mask;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic       m_act [2][32];
    logic       m_zero[2][32];
    logic       m_inv [2][32];
    logic [4:0] m_ridx[2][32];

    always #5 clk = ~clk;

    pred_mask_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_fp(wr_fp), .wr_slot(wr_slot),
        .wr_active(wr_active), .wr_zero(wr_zero), .wr_inv(wr_inv), .wr_ridx(wr_ridx),
        .req_valid(req_valid), .req_fp(req_fp), .req_slot(req_slot),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .mask_valid(mask_valid), .mask(mask), .zeroing(zeroing)
    );

    function automatic logic [XLEN-1:0] rfval(logic [4:0] a);
        if (a == 0) return 32'hDEAD_BEEF;
        return (32'h9E37_79B1 * (32'(a) + 1)) ^ (32'(a) << 20);
    endfunction

    always_comb rf_rdata = rfval(rf_raddr);

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_mask(int c, int s);
        logic [XLEN-1:0] raw;
        if (!m_act[c][s]) return '1;
        raw = (m_ridx[c][s] == 0) ? '0 : rfval(m_ridx[c][s]);
        return m_inv[c][s] ? ~raw : raw;
    endfunction

    task automatic set_wr(int c, int s, logic a, logic z, logic i, logic [4:0] r);
        wr_en = 1; wr_fp = c[0]; wr_slot = s[4:0];
        wr_active = a; wr_zero = z; wr_inv = i; wr_ridx = r;
    endtask

    task automatic upd_model(int c, int s, logic a, logic z, logic i, logic [4:0] r);
        m_act[c][s] = a; m_zero[c][s] = z; m_inv[c][s] = i; m_ridx[c][s] = r;
    endtask

    task automatic write_ent(int c, int s, logic a, logic z, logic i, logic [4:0] r);
        @(negedge clk);
        set_wr(c, s, a, z, i, r);
        @(negedge clk);
        wr_en = 0;
        upd_model(c, s, a, z, i, r);
    endtask

    task automatic lookup(int c, int s, string tag);
        logic [XLEN-1:0] e;
        @(negedge clk);
        req_valid = 1; req_fp = c[0]; req_slot = s[4:0];
        #1;
        if (m_act[c][s]) chk({tag, " R4 raddr"}, 32'(rf_raddr), 32'(m_ridx[c][s]));
        e = exp_mask(c, s);
        @(negedge clk);
        req_valid = 0;
        chk({tag, " R2 strobe"}, 32'(mask_valid), 32'd1);
        chk({tag, " mask R3/R4/R5/R7"}, mask, e);
        chk({tag, " R6 zeroing"}, 32'(zeroing), 32'(m_act[c][s] & m_zero[c][s]));
    endtask

    initial begin
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 32; s++) upd_model(c, s, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1 valid", 32'(mask_valid), 0);
        chk("R1 mask", mask, '1);
        chk("R1 zeroing", 32'(zeroing), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R2 idle no strobe", 32'(mask_valid), 0);
        // R1: every entry disabled after reset
        for (int c = 0; c < 2; c++) begin
            lookup(c, 0, "R1 reset entry");
            lookup(c, 31, "R1 reset entry");
        end

        // sweep: every slot, both classes, all flag combinations (R3..R7)
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 32; s++)
                for (int f = 0; f < 8; f++) begin
                    write_ent(c, s, f[0], f[1], f[2], 5'((s * 7 + f + c * 3) % 32));
                    lookup(c, s, "sweep");
                end

        // R7: register 0 with rf data nonzero
        write_ent(0, 4, 1, 0, 0, 0);
        lookup(0, 4, "R7 x0 plain");
        write_ent(0, 4, 1, 1, 1, 0);
        lookup(0, 4, "R7 x0 inverted");

        // R8: class separation
        write_ent(0, 9, 1, 1, 1, 5'd13);
        write_ent(1, 9, 0, 1, 0, 5'd22);
        lookup(0, 9, "R8 int");
        lookup(1, 9, "R8 fp");
        chk("R8 fp untouched", mask, '1);
        write_ent(1, 9, 1, 0, 0, 5'd22);
        lookup(0, 9, "R8 int after fp write");

        // R9: write and lookup of same slot in one cycle sees old entry
        write_ent(0, 17, 0, 0, 0, 5'd3);
        @(negedge clk);
        set_wr(0, 17, 1, 1, 0, 5'd3);
        req_valid = 1; req_fp = 0; req_slot = 5'd17;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        chk("R9 same-cycle old mask", mask, '1);
        chk("R9 same-cycle old zeroing", 32'(zeroing), 0);
        upd_model(0, 17, 1, 1, 0, 5'd3);
        lookup(0, 17, "R9 next cycle");

        // R2: back-to-back requests
        @(negedge clk);
        req_valid = 1; req_fp = 0; req_slot = 5'd9;
        @(negedge clk);
        chk("R2 b2b first strobe", 32'(mask_valid), 1);
        chk("R2 b2b first mask", mask, exp_mask(0, 9));
        req_fp = 1; req_slot = 5'd9;
        @(negedge clk);
        req_valid = 0;
        chk("R2 b2b second strobe", 32'(mask_valid), 1);
        chk("R2 b2b second mask", mask, exp_mask(1, 9));

        // R10: hold while idle, table writes do not disturb outputs
        write_ent(1, 9, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10 hold mask", mask, exp_mask(0, 9) ^ exp_mask(0, 9) ^ rfval(5'd22));
        chk("R10 hold zeroing", 32'(zeroing), 0);
        chk("R2 idle strobe low", 32'(mask_valid), 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule